// File: doc/BRIEF.md
# Chainable Serial Command Receiver

This block is the serial slave front end of a multi-output switch controller. While the active-low chip select is held low, it samples command bits on rising serial-clock edges, most significant bit first. On the data-out line it first presents a 16-bit status word, which is captured when chip select falls. After that it presents the bits it received sixteen serial clocks earlier, so several devices can share one chain.

When chip select rises, the block checks how many serial clocks the window held. If the count is a non-zero multiple of 16, the block decodes the last complete 16-bit word. Bit 15 is a watchdog bit, bits 14..12 are a register address and bits 11..0 are a control value. The control value is written into one of six registers, and a one-cycle write strobe marks the write. A frame of any other length is dropped whole. All logic runs on a fast system clock, and the chip-select and serial-clock inputs are treated as already synchronous to that clock. The output drivers, fault detection and the watchdog timeout timer sit outside this block.

Top module: `spi_cmd_rx`

## Requirements
- R1: Words are 16 bits, sent most significant bit first. In the word that is committed, bit 15 is the watchdog bit, bits 14..12 are the address and bits 11..0 are the data. Address a in 0..5 loads the data into register a, which appears on regs_o[a*12 +: 12].
- R2: A window is committed when its number of rising serial clocks is a non-zero multiple of 16. Only the last 16 bits received are decoded.
- R3: A window whose rising-clock count is zero or not a multiple of 16 changes no register, raises no write strobe and raises no watchdog indication.
- R4: Address codes 6 and 7 write no register and raise no strobe. The watchdog bit of such a word is still evaluated.
- R5: A commit raises exactly one bit of wr_stb_o, the bit for the written address. It goes high in the first clock cycle after chip select rises and stays high for one cycle only.
- R6: wd_toggle_o pulses together with the commit when the watchdog bit differs from the watchdog bit of the previous committed window. The stored watchdog bit is 0 after reset.
- R7: During the first 16 serial clocks, so_o presents status_i as sampled at the chip-select fall, most significant bit first. It changes on falling serial clocks, and later changes of status_i do not affect it.
- R8: From serial clock 17 onward, so_o presents the serial input bit received 16 serial clocks earlier.
- R9: so_oe_o is 1 only while chip select is low. so_o is 0 whenever so_oe_o is 0.
- R10: While rst_ni is low, all registers, strobes and the watchdog indication are 0, and so_oe_o is 0.
- R11: Serial-clock edges while chip select is high are ignored. They do not disturb the bit count of the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock, idles low |
| si_i | input | 1 | Serial data in |
| status_i | input | 16 | Status word captured at chip-select fall |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| regs_o | output | 72 | Six 12-bit control registers, register a at bits a*12 +: 12 |
| wr_stb_o | output | 6 | One-hot write strobe, one bit per register |
| wd_toggle_o | output | 1 | Pulse when a committed watchdog bit differs from the previous one |

## Verification
The assertions check four things on every cycle. Write strobes are one-hot and last a single cycle. Registers hold whenever no strobe is raised. Out-of-range addresses never produce a strobe. The receive shift register never moves while chip select is high. Only the directed scenarios can show the rest: which word a long chained frame commits, the exact data-out bit sequence of status followed by delayed input, the rejection of 15- and 17-bit frames, and the watchdog toggle history across frames.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 12;
  localparam int NUM_REGS = 6;

  typedef struct packed {
    logic              wd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_cmd_edge.sv
module spi_cmd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic cs_q_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  logic cs_q, sclk_q, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      sclk_q <= sclk_i;
    end
  end

  // serial edges count only inside a settled window
  assign active      = !cs_ni && !cs_q;
  assign sclk_rise_o = active && sclk_i && !sclk_q;
  assign sclk_fall_o = active && !sclk_i && sclk_q;
  assign cs_fall_o   = !cs_ni && cs_q;
  assign cs_rise_o   = cs_ni && !cs_q;
  assign cs_q_o      = cs_q;
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int WORD_W = spi_cmd_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              so_bit_o,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (cs_fall_i) begin
      tx_q   <= status_i;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (sclk_rise_i) begin
        rx_q <= {rx_q[WORD_W-2:0], si_i};
        if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      // pass the newest sampled bit down the out-chain
      if (sclk_fall_i) tx_q <= {tx_q[WORD_W-2:0], rx_q[0]};
    end
  end

  assign so_bit_o = tx_q[WORD_W-1];
  assign word_o   = rx_q;
  assign commit_o = cs_rise_i && full_q && (cnt_q == '0);

  assert_rx_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(rx_q));
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile #(
  parameter int NUM_REGS = spi_cmd_pkg::NUM_REGS,
  parameter int ADDR_W   = spi_cmd_pkg::ADDR_W,
  parameter int DATA_W   = spi_cmd_pkg::DATA_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              commit_i,
  input  spi_cmd_pkg::cmd_t                 cmd_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o,
  output logic [NUM_REGS-1:0]               wr_stb_o,
  output logic                              wd_toggle_o
);
  localparam logic [ADDR_W:0] NREG = (ADDR_W+1)'(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0]             sel, stb_q;
  logic                            addr_ok, wd_prev_q, wd_tgl_q;

  assign addr_ok = ({1'b0, cmd_i.addr} < NREG);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = commit_i && addr_ok && (cmd_i.addr == ADDR_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q    <= '0;
      stb_q     <= '0;
      wd_prev_q <= 1'b0;
      wd_tgl_q  <= 1'b0;
    end else begin
      stb_q    <= sel;
      wd_tgl_q <= commit_i && (cmd_i.wd != wd_prev_q);
      if (commit_i) wd_prev_q <= cmd_i.wd;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (sel[i]) regs_q[i] <= cmd_i.data;
      end
    end
  end

  assign regs_o      = regs_q;
  assign wr_stb_o    = stb_q;
  assign wd_toggle_o = wd_tgl_q;

  assert_stb_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_q));
  assert_stb_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q != '0) |=> (stb_q == '0));
  assert_reg_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q == '0) |-> $stable(regs_q));
  assert_bad_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !addr_ok) |=> (stb_q == '0));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int WORD_W   = spi_cmd_pkg::WORD_W,
  parameter int NUM_REGS = spi_cmd_pkg::NUM_REGS,
  parameter int DATA_W   = spi_cmd_pkg::DATA_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cs_ni,
  input  logic                         sclk_i,
  input  logic                         si_i,
  input  logic [WORD_W-1:0]            status_i,
  output logic                         so_o,
  output logic                         so_oe_o,
  output logic [NUM_REGS*DATA_W-1:0]   regs_o,
  output logic [NUM_REGS-1:0]          wr_stb_o,
  output logic                         wd_toggle_o
);
  logic cs_q, cs_fall, cs_rise, sclk_rise, sclk_fall, so_bit, commit;
  logic [WORD_W-1:0] word;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  spi_cmd_pkg::cmd_t cmd;

  spi_cmd_edge u_edge (
    .clk_i, .rst_ni, .cs_ni, .sclk_i,
    .cs_q_o(cs_q), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall)
  );

  spi_cmd_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .cs_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .si_i, .status_i,
    .so_bit_o(so_bit), .word_o(word), .commit_o(commit)
  );

  assign cmd = spi_cmd_pkg::cmd_t'(word);

  spi_cmd_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .commit_i(commit), .cmd_i(cmd),
    .regs_o(regs), .wr_stb_o, .wd_toggle_o
  );

  assign regs_o  = regs;
  assign so_oe_o = !cs_q;
  assign so_o    = so_oe_o & so_bit;
endmodule

// File: tb/spi_cmd_rx_tb.sv
`timescale 1ns/1ps
module spi_cmd_rx_tb;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, si = 0;
  logic [15:0] status = '0;
  logic so, so_oe, wd_tgl;
  logic [71:0] regs;
  logic [5:0] stb;
  int checks = 0, errors = 0;

  logic [71:0] m_regs = '0;
  logic        m_wd = 0;
  logic [5:0]  got_stb, got_stb2;
  logic        got_wd;
  logic [71:0] got_regs;

  always #2.5 clk = ~clk;

  spi_cmd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .si_i(si),
    .status_i(status), .so_o(so), .so_oe_o(so_oe), .regs_o(regs),
    .wr_stb_o(stb), .wd_toggle_o(wd_tgl)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one chip-select window; compares SO bitwise and the commit outcome
  task automatic frame(input logic [63:0] vec, input int nbits, input logic [15:0] st, input string req);
    int so_err = 0;
    logic [15:0] w;
    logic [5:0] e_stb = '0;
    logic e_wd = 0;
    logic exp_so;
    status = st;
    cs_n = 0;
    tick(2);
    status = ~st;
    chk(so_oe == 1'b1, "R9 oe low window", {71'd0, so_oe}, 72'd1);
    for (int i = 0; i < nbits; i++) begin
      si = vec[nbits-1-i];
      tick(1);
      exp_so = (i < 16) ? st[15-i] : vec[nbits-1-(i-16)];
      if (so !== exp_so) so_err++;
      sclk = 1;
      tick(2);
      sclk = 0;
      tick(2);
    end
    if (nbits > 0)
      chk(so_err == 0, (nbits > 16) ? "R7 R8 so sequence" : "R7 so status", so_err, 0);
    cs_n = 1;
    tick(1);
    got_stb = stb; got_wd = wd_tgl; got_regs = regs;
    chk(so_oe == 0 && so == 0, "R9 idle so", {70'd0, so_oe, so}, 0);
    tick(1);
    got_stb2 = stb;
    w = vec[15:0];
    if (nbits > 0 && nbits % 16 == 0) begin
      e_wd = (w[15] != m_wd);
      m_wd = w[15];
      if (w[14:12] < 3'd6) begin
        m_regs[w[14:12]*12 +: 12] = w[11:0];
        e_stb = 6'b1 << w[14:12];
      end
    end
    chk(got_regs == m_regs, {req, " regs"}, got_regs, m_regs);
    chk(got_stb == e_stb, {req, " strobe"}, got_stb, e_stb);
    chk(got_wd == e_wd, "R6 watchdog toggle", got_wd, e_wd);
    chk(got_stb2 == 0, "R5 strobe single cycle", got_stb2, 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    tick(2);
    m_regs = '0; m_wd = 0;
    chk(regs == 0 && stb == 0 && wd_tgl == 0, "R10 regs in reset", regs, 0);
    chk(so_oe == 0 && so == 0, "R10 so in reset", {70'd0, so_oe, so}, 0);
    rst_n = 1;
    tick(2);
  endtask

  task automatic t_single();
    frame({48'd0, 1'b0, 3'd2, 12'hA5C}, 16, 16'hC3A5, "R1 single write");
    chk(got_stb == 6'b000100, "R5 strobe bit for address 2", got_stb, 6'b000100);
  endtask

  task automatic t_all_regs();
    for (int a = 0; a < 6; a++)
      frame({48'd0, m_wd, 3'(a), 12'(12'h111 * (a + 1))}, 16, 16'h5A00 + 16'(a), "R1 each address");
  endtask

  task automatic t_watchdog();
    frame({48'd0, 1'b1, 3'd0, 12'h001}, 16, 16'h0F0F, "R6 wd rise");
    chk(got_wd == 1, "R6 toggle on change", got_wd, 1);
    frame({48'd0, 1'b1, 3'd1, 12'h002}, 16, 16'hF0F0, "R6 wd same");
    chk(got_wd == 0, "R6 no toggle when equal", got_wd, 0);
    frame({48'd0, 1'b0, 3'd7, 12'h003}, 16, 16'h1234, "R4 R6 wd on bad address");
    chk(got_wd == 1, "R4 watchdog still evaluated", got_wd, 1);
  endtask

  task automatic t_bad_len();
    frame({49'd0, 1'b1, 3'd3, 11'h7FF}, 15, 16'h8001, "R3 15 bits");
    frame({47'd0, 1'b1, 1'b1, 3'd3, 12'hFFF}, 17, 16'h8001, "R3 17 bits");
    frame(64'd0, 0, 16'h8001, "R3 zero clocks");
    chk(got_stb == 0 && got_wd == 0, "R3 nothing committed", {65'd0, got_wd, got_stb}, 0);
  endtask

  task automatic t_bad_addr();
    frame({48'd0, 1'b0, 3'd6, 12'hBEE}, 16, 16'h4242, "R4 address 6");
    frame({48'd0, 1'b0, 3'd7, 12'hCAF}, 16, 16'h2424, "R4 address 7");
    chk(got_stb == 0, "R4 no strobe", got_stb, 0);
  endtask

  task automatic t_chain();
    frame({16'h0, 16'h9ABC, 16'h2123, 1'b1, 3'd4, 12'h6E7}, 48, 16'hE817, "R2 last of three words");
    chk(got_regs[48 +: 12] == 12'h6E7, "R2 address 4 takes last word", got_regs[48 +: 12], 12'h6E7);
    frame({1'b0, 3'd5, 12'h321, 16'h7777, 16'h0000, 1'b0, 3'd5, 12'h0AB}, 64, 16'h6006, "R2 last of four words");
  endtask

  task automatic t_cs_high();
    for (int k = 0; k < 5; k++) begin
      sclk = 1; tick(2);
      chk(so == 0 && so_oe == 0 && stb == 0, "R11 R9 idle edges", {69'd0, so_oe, so, |stb}, 0);
      sclk = 0; tick(2);
    end
    frame({48'd0, 1'b0, 3'd1, 12'h5D5}, 16, 16'hAAAA, "R11 count after idle edges");
  endtask

  initial begin
    tick(3);
    chk(regs == 0 && stb == 0 && so_oe == 0, "R10 initial reset", regs, 0);
    rst_n = 1;
    tick(2);
    t_single();
    t_all_regs();
    t_watchdog();
    t_bad_len();
    t_bad_addr();
    t_chain();
    t_cs_high();
    t_reset();
    frame({48'd0, 1'b0, 3'd3, 12'h00F}, 16, 16'h1357, "R10 after reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule